// File: doc/BRIEF.md
# Board Test Command Frame Responder

This block sits on the device side of a board test link. Bytes arrive from a UART receiver through a byte interface that has a valid strobe and no ready. The block collects them into command frames of eight bytes each. When a frame is complete it acts on it at once. It can sample the 32 input pins and report them, or it can set the 32 output pins and confirm the write. In both cases it sends an 8-byte reply through a valid/ready byte interface to a UART transmitter.

A frame whose header byte or opcode bytes are wrong is dropped and gives no reply. If the line goes quiet for a set number of cycles, a partly received frame is thrown away, so the next byte always starts a new frame. Input pins pass through a synchronizer of two or more stages before they are sampled. Bytes that arrive while a reply is in progress are ignored.

Top module: `test_cmd_responder`

## Requirements
- R1: A command is eight bytes, and byte 0 must be 0xA5. A read command has bytes 1, 2 and 3 equal to 0xD1, 0xC1 and 0xD1. The values of its bytes 4 to 7 have no effect.
- R2: A read command gives the reply 0xA5, 0xC1, 0xD1, 0xD2, followed by input bits [7:0], [15:8], [23:16] and [31:24], in that order.
- R3: A drive command has bytes 1, 2 and 3 equal to 0xC1, 0xD1 and 0xD3. Its byte 4+k is written to output pins [8k+7:8k], for k from 0 to 3.
- R4: A drive command gives the acknowledge reply 0xA5, 0xA1, 0xD1, 0xAC, 0x5A, 0x5A, 0x5A, 0x5A.
- R5: The output pins change only on the cycle in which tx_valid first rises for the acknowledge. So the new value is already on the pins when the byte 0xA5 is first presented.
- R6: A frame is dropped if byte 0 is not 0xA5, or if bytes 1 to 3 match neither command. A dropped frame gives no reply and leaves the output pins unchanged.
- R7: If IDLE_CYCLES or more clock cycles pass without an accepted byte, a partial frame is discarded. A shorter gap does not discard it. IDLE_CYCLES = 0 turns the timeout off.
- R8: A byte is dropped if it arrives between the acceptance of the last byte of a valid command and the handshake of the last reply byte, that handshake cycle included. Such a byte neither starts nor adds to a frame.
- R9: While tx_valid is high and tx_ready is low, tx_valid stays high and tx_data holds its value.
- R10: During and after reset, pins_out is 0, tx_valid is 0 and the byte count is empty.
- R11: The reported input value is the output of the synchronizer on the edge that accepts byte 7. With two stages, a pin change driven one cycle before that edge is not reported, and a change driven two cycles before it is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Reply byte available |
| tx_ready | input | 1 | Transmitter takes the reply byte |
| tx_data | output | 8 | Reply byte |
| pins_in | input | 32 | Asynchronous input pins |
| pins_out | output | 32 | Driven output pins |

## Verification
The bench builds the block with IDLE_CYCLES = 20 and SYNC_STAGES = 2. The short timeout lets the test show both sides of the discard threshold, an 11-cycle gap that keeps the frame and a 30-cycle gap that clears it, within a few dozen cycles. With two synchronizer stages, the exact sampling edge can be pinned down by moving a pin change one cycle at a time before the last command byte. A reply held off by tx_ready low keeps the block busy, which exposes the window in which bytes are dropped.

// File: rtl/tcr_pkg.sv
`timescale 1ns/1ps
package tcr_pkg;
   localparam int FRAME_LEN   = 8;
   localparam int HDR_LEN     = 4;
   localparam int PAYLOAD_LEN = FRAME_LEN - HDR_LEN;
   localparam int PIN_W       = 8 * PAYLOAD_LEN;
   localparam int PTR_W       = $clog2(FRAME_LEN);

   localparam logic [7:0]  SOF_BYTE  = 8'hA5;
   localparam logic [23:0] OP_READ   = 24'hD1C1D1;
   localparam logic [23:0] OP_DRIVE  = 24'hC1D1D3;
   localparam logic [23:0] TAG_READ  = 24'hC1D1D2;
   localparam logic [23:0] TAG_ACK   = 24'hA1D1AC;
   localparam logic [7:0]  ACK_FILL  = 8'h5A;

   typedef logic [FRAME_LEN-1:0][7:0] frame_t;
   typedef logic [HDR_LEN-1:0][7:0]   header_t;
   typedef enum logic [1:0] {CMD_NONE, CMD_READ, CMD_DRIVE} cmd_e;
endpackage

// File: rtl/tcr_in_sync.sv
`timescale 1ns/1ps
module tcr_in_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tcr_in_sync needs at least two stages");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain_q[s] <= '0;
               else        chain_q[s] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) chain_q[s] <= '0;
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/tcr_frame_rx.sv
`timescale 1ns/1ps
module tcr_frame_rx
   import tcr_pkg::*;
#(
   parameter int IDLE_CYCLES = 1000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_valid,
   input  logic [7:0] rx_data,
   input  logic       hold,
   output logic       frame_done,
   output frame_t     frame_o
);
   localparam int IW = (IDLE_CYCLES > 2) ? $clog2(IDLE_CYCLES) : 1;

   logic [PTR_W-1:0]           cnt_q;
   logic [FRAME_LEN-2:0][7:0]  buf_q;
   logic                       accept;
   logic                       last;
   logic                       expire;

   assign accept     = rx_valid && !hold;
   assign last       = (cnt_q == PTR_W'(FRAME_LEN-1));
   assign frame_done = accept && last;

   always_comb begin
      for (int i = 0; i < FRAME_LEN-1; i++) frame_o[i] = buf_q[i];
      frame_o[FRAME_LEN-1] = rx_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         buf_q <= '0;
      end else if (accept) begin
         for (int i = 0; i < FRAME_LEN-1; i++)
            if (cnt_q == PTR_W'(i)) buf_q[i] <= rx_data;
         cnt_q <= last ? '0 : cnt_q + 1'b1;
      end else if (expire) begin
         cnt_q <= '0;
      end
   end

   generate
      if (IDLE_CYCLES > 0) begin : g_timeout
         logic [IW-1:0] idle_q;
         always_ff @(posedge clk) begin
            if (!rst_n || accept || cnt_q == '0) idle_q <= '0;
            else if (idle_q != IW'(IDLE_CYCLES-1)) idle_q <= idle_q + 1'b1;
         end
         assign expire = (cnt_q != '0) && !accept && (idle_q == IW'(IDLE_CYCLES-1));
      end else begin : g_no_timeout
         assign expire = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/tcr_decode.sv
`timescale 1ns/1ps
module tcr_decode
   import tcr_pkg::*;
(
   input  header_t hdr,
   output cmd_e    cmd
);
   logic [23:0] op;
   assign op = {hdr[1], hdr[2], hdr[3]};

   always_comb begin
      cmd = CMD_NONE;
      if (hdr[0] == SOF_BYTE) begin
         if (op == OP_READ)       cmd = CMD_READ;
         else if (op == OP_DRIVE) cmd = CMD_DRIVE;
      end
   end
endmodule

// File: rtl/tcr_tx.sv
`timescale 1ns/1ps
module tcr_tx
   import tcr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  frame_t     load_frame,
   input  logic       tx_ready,
   output logic       tx_valid,
   output logic [7:0] tx_data,
   output logic       busy
);
   frame_t           buf_q;
   logic [PTR_W-1:0] idx_q;
   logic             active_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         buf_q    <= '0;
         idx_q    <= '0;
         active_q <= 1'b0;
      end else if (load) begin
         buf_q    <= load_frame;
         idx_q    <= '0;
         active_q <= 1'b1;
      end else if (active_q && tx_ready) begin
         if (idx_q == PTR_W'(FRAME_LEN-1)) active_q <= 1'b0;
         else                              idx_q    <= idx_q + 1'b1;
      end
   end

   assign tx_valid = active_q;
   assign tx_data  = buf_q[idx_q];
   assign busy     = active_q;
endmodule

// File: rtl/test_cmd_responder.sv
`timescale 1ns/1ps
module test_cmd_responder
   import tcr_pkg::*;
#(
   parameter int IDLE_CYCLES = 1000,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_valid,
   input  logic [7:0]       rx_data,
   output logic             tx_valid,
   input  logic             tx_ready,
   output logic [7:0]       tx_data,
   input  logic [PIN_W-1:0] pins_in,
   output logic [PIN_W-1:0] pins_out
);
   generate
      if (IDLE_CYCLES < 0) begin : g_bad_idle
         $error("IDLE_CYCLES must not be negative");
      end
      if (PIN_W != 8 * PAYLOAD_LEN) begin : g_bad_width
         $error("pin width must match the payload");
      end
   endgenerate

   logic [PIN_W-1:0] pins_sync;
   logic [PIN_W-1:0] pins_q;
   logic             frame_done;
   frame_t           frame;
   cmd_e             cmd;
   logic             tx_busy;
   logic             load;
   frame_t           reply;

   tcr_in_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_async(pins_in), .q_sync(pins_sync)
   );

   tcr_frame_rx #(.IDLE_CYCLES(IDLE_CYCLES)) u_rx (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .hold(tx_busy), .frame_done(frame_done), .frame_o(frame)
   );

   tcr_decode u_dec (
      .hdr(frame[HDR_LEN-1:0]), .cmd(cmd)
   );

   assign load = frame_done && (cmd != CMD_NONE);

   always_comb begin
      reply[0] = SOF_BYTE;
      if (cmd == CMD_DRIVE) begin
         reply[1] = TAG_ACK[23:16];
         reply[2] = TAG_ACK[15:8];
         reply[3] = TAG_ACK[7:0];
         for (int k = 0; k < PAYLOAD_LEN; k++) reply[HDR_LEN+k] = ACK_FILL;
      end else begin
         reply[1] = TAG_READ[23:16];
         reply[2] = TAG_READ[15:8];
         reply[3] = TAG_READ[7:0];
         for (int k = 0; k < PAYLOAD_LEN; k++) reply[HDR_LEN+k] = pins_sync[8*k +: 8];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pins_q <= '0;
      end else if (frame_done && cmd == CMD_DRIVE) begin
         for (int k = 0; k < PAYLOAD_LEN; k++) pins_q[8*k +: 8] <= frame[HDR_LEN+k];
      end
   end

   assign pins_out = pins_q;

   tcr_tx u_tx (
      .clk(clk), .rst_n(rst_n), .load(load), .load_frame(reply),
      .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .busy(tx_busy)
   );
endmodule

// File: rtl/tcr_chk.sv
`timescale 1ns/1ps
module tcr_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        rx_valid,
   input logic        tx_valid,
   input logic        tx_ready,
   input logic [7:0]  tx_data,
   input logic [31:0] pins_out
);
   // R9
   valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready |=> tx_valid);

   // R9
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready |=> $stable(tx_data));

   // R2
   reply_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_valid) |-> tx_data == 8'hA5);

   // R1
   reply_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_valid) |-> $past(rx_valid));

   // R5
   pins_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pins_out) |-> $rose(tx_valid));
endmodule

bind test_cmd_responder tcr_chk u_chk (
   .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .tx_valid(tx_valid),
   .tx_ready(tx_ready), .tx_data(tx_data), .pins_out(pins_out)
);

// File: tb/sim_test_cmd_responder.sv
`timescale 1ns/1ps
module sim_test_cmd_responder;
   localparam int IDLE = 20;
   localparam int NV   = 8;
   localparam logic [63:0] ACK = 64'hA5A1D1AC5A5A5A5A;

   localparam logic [63:0] V_CMD [NV] = '{
      64'hA5D1C1D1_00000000, 64'hA5C1D1D3_11223344, 64'h5AC1D1D3_99999999,
      64'hA5C1D1D4_99999999, 64'hA5D1C1D1_FFFFFFFF, 64'hA5C1D1D3_00FF00FF,
      64'hA5D1C1D2_00000000, 64'hA5D1C1D1_13579BDF };
   localparam logic [31:0] V_PIN [NV] = '{
      32'h12345678, 32'h0, 32'h0, 32'h0, 32'hDEADBEEF, 32'h0, 32'h0, 32'h00000000 };
   localparam logic [63:0] V_RSP [NV] = '{
      64'hA5C1D1D2_78563412, ACK, 64'h0, 64'h0, 64'hA5C1D1D2_EFBEADDE, ACK,
      64'h0, 64'hA5C1D1D2_00000000 };
   localparam bit V_HAS [NV] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
   localparam logic [31:0] V_OUT [NV] = '{
      32'h0, 32'h44332211, 32'h44332211, 32'h44332211, 32'h44332211,
      32'hFF00FF00, 32'hFF00FF00, 32'hFF00FF00 };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_data = 8'h0;
   logic        tx_valid;
   logic        tx_ready = 1'b0;
   logic [7:0]  tx_data;
   logic [31:0] pins_in = 32'h0;
   logic [31:0] pins_out;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   test_cmd_responder #(.IDLE_CYCLES(IDLE), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
      .pins_in(pins_in), .pins_out(pins_out)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic send_byte(input logic [7:0] b);
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = b;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic send_frame(input logic [63:0] f, input int gap_pos, input int gap_len);
      for (int k = 0; k < 8; k++) begin
         send_byte(f[63-8*k -: 8]);
         if (k == gap_pos) repeat (gap_len) @(negedge clk);
      end
   endtask

   task automatic collect(input bit toggle, input int maxcyc,
                          output logic [63:0] r, output int n, output logic [31:0] pins_first);
      bit seen = 1'b0;
      r = '0;
      n = 0;
      pins_first = '0;
      for (int c = 0; c < maxcyc; c++) begin
         @(negedge clk);
         tx_ready = toggle ? c[0] : 1'b1;
         if (tx_valid && !seen) begin
            seen = 1'b1;
            pins_first = pins_out;
         end
         if (tx_valid && tx_ready) begin
            r = {r[55:0], tx_data};
            n++;
         end
      end
      @(negedge clk);
      tx_ready = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [63:0] r;
      int          n;
      logic [31:0] pf;

      repeat (4) @(negedge clk);
      // R10 reset state
      chk(pins_out == 32'h0, "R10 pins_out in reset", 64'(pins_out), 64'h0);
      chk(tx_valid == 1'b0, "R10 tx_valid in reset", 64'(tx_valid), 64'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(pins_out == 32'h0, "R10 pins_out after reset", 64'(pins_out), 64'h0);

      for (int v = 0; v < NV; v++) begin
         pins_in = V_PIN[v];
         repeat (4) @(negedge clk);
         send_frame(V_CMD[v], 99, 0);
         collect(v[0], 40, r, n, pf);
         if (V_HAS[v]) begin
            chk(n == 8, (V_RSP[v] == ACK) ? "R4 ack length" : "R2 reply length", 64'(n), 64'd8);
            chk(r == V_RSP[v], (V_RSP[v] == ACK) ? "R4 ack frame" : "R2 read reply R1", r, V_RSP[v]);
            if (V_RSP[v] == ACK)
               chk(pf == V_OUT[v], "R5 pins before ack", 64'(pf), 64'(V_OUT[v]));
         end else begin
            chk(n == 0, "R6 no reply to bad frame", 64'(n), 64'd0);
         end
         chk(pins_out == V_OUT[v], "R3 pins_out R6", 64'(pins_out), 64'(V_OUT[v]));
      end

      // R7 long gap clears a partial frame
      send_byte(8'hA5); send_byte(8'hC1); send_byte(8'hD1);
      repeat (30) @(negedge clk);
      pins_in = 32'hCAFEF00D;
      repeat (4) @(negedge clk);
      send_frame(64'hA5D1C1D1_00000000, 99, 0);
      collect(1'b0, 30, r, n, pf);
      chk(r == 64'hA5C1D1D2_0DF0FECA && n == 8, "R7 timeout clears partial", r, 64'hA5C1D1D2_0DF0FECA);
      chk(pins_out == 32'hFF00FF00, "R7 pins unchanged", 64'(pins_out), 64'hFF00FF00);

      // R7 short gap keeps the frame
      send_frame(64'hA5D1C1D1_00000000, 3, 10);
      collect(1'b0, 30, r, n, pf);
      chk(r == 64'hA5C1D1D2_0DF0FECA && n == 8, "R7 short gap kept", r, 64'hA5C1D1D2_0DF0FECA);

      // R8 bytes during a pending reply are dropped
      tx_ready = 1'b0;
      send_frame(64'hA5C1D1D3_0A0B0C0D, 99, 0);
      send_frame(64'hA5C1D1D3_01020304, 99, 0);
      collect(1'b0, 30, r, n, pf);
      chk(r == ACK && n == 8, "R8 single ack", r, ACK);
      chk(pins_out == 32'h0D0C0B0A, "R8 dropped drive", 64'(pins_out), 64'h0D0C0B0A);
      collect(1'b0, 30, r, n, pf);
      chk(n == 0, "R8 no second reply", 64'(n), 64'd0);
      send_frame(64'hA5D1C1D1_00000000, 99, 0);
      collect(1'b0, 30, r, n, pf);
      chk(r == 64'hA5C1D1D2_0DF0FECA, "R8 clean boundary after drop", r, 64'hA5C1D1D2_0DF0FECA);

      // R11 synchronizer sampling edge
      for (int lead = 1; lead <= 2; lead++) begin
         pins_in = 32'h11111111;
         repeat (4) @(negedge clk);
         for (int k = 0; k < 7; k++) send_byte(8'(64'hA5D1C1D1_00000000 >> (56 - 8*k)));
         @(negedge clk);
         pins_in = 32'h22222222;
         repeat (lead) @(negedge clk);
         rx_valid = 1'b1;
         rx_data  = 8'h00;
         @(negedge clk);
         rx_valid = 1'b0;
         collect(1'b0, 30, r, n, pf);
         if (lead == 1)
            chk(r == 64'hA5C1D1D2_11111111, "R11 late change unseen", r, 64'hA5C1D1D2_11111111);
         else
            chk(r == 64'hA5C1D1D2_22222222, "R11 early change seen", r, 64'hA5C1D1D2_22222222);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule